// File: doc/BRIEF.md
# Case-Inverting Serial Echo Controller

This controller sits between the receive and transmit halves of an on-chip serial port. It takes one received byte at a time over a ready/valid handshake. ASCII letters have their case swapped and every other byte passes through unchanged. The result goes into a one-entry holding register, which the transmit half drains over a second ready/valid handshake. A new byte is not taken until the pending one has been sent, so at most one byte is in flight.

The block also conditions a reset. A debounced push-button level enters the block, and each rising edge of that level produces a local reset pulse exactly one clock wide. The pulse returns the handshake logic to idle, drops any pending byte, and holds both handshake outputs low while it is active. A separate synchronous system reset clears everything, including the edge detector. The intended setting is a 125 MHz clock feeding a 115200 baud link; the block itself does not depend on either rate.

Top module: `case_echo_ctrl`

## Requirements
- R1: A received byte in 0x41..0x5A is sent back with 0x20 added (upper to lower case), so 0x41 returns as 0x61.
- R2: A received byte in 0x61..0x7A is sent back with 0x20 subtracted (lower to upper case).
- R3: Any other byte is echoed unchanged, including the neighbours 0x40, 0x5B, 0x60, 0x7B and bytes with bit 7 set.
- R4: When `rx_valid` is high while the block is idle, `rx_ready` goes high for exactly one cycle, starting one clock later. The byte is taken at the edge where both are high.
- R5: `tx_valid` rises on the cycle after the receive handshake. It stays high with `tx_data` unchanged until `tx_ready` is seen, unless a reset intervenes.
- R6: After the clock edge where `tx_valid` and `tx_ready` are both high, `tx_valid` is low on the next cycle.
- R7: While a byte waits to be transmitted, `rx_ready` stays low whatever `rx_valid` does. A byte offered then is not consumed, and the held byte is not altered.
- R8: A rising edge of `btn_rst_level` gives `soft_rst` high for exactly one cycle, one clock after the edge is sampled. Holding the level high gives no further pulse.
- R9: While `soft_rst` is high, `rx_ready` and `tx_valid` are low. Afterwards the block is idle and any pending byte is discarded.
- R10: With `rst` high at a clock edge, `rx_ready`, `tx_valid` and `soft_rst` are low from that edge on, and any pending byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| btn_rst_level | input | 1 | Debounced button level; its rising edge requests a local reset |
| rx_data | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | Receiver has a byte |
| rx_ready | output | 1 | Controller takes the byte on this cycle |
| tx_data | output | 8 | Transformed byte to the transmitter |
| tx_valid | output | 1 | Transformed byte is waiting |
| tx_ready | input | 1 | Transmitter accepts the byte |
| soft_rst | output | 1 | One-cycle reset pulse from the button edge |

## Verification
All 256 byte values are sent through the block. This separates the two letter ranges from their immediate neighbours, and from bytes that differ from a letter only in bit 7, so an off-by-one range bound or a missing bit-7 test in the letter detection shows up. Each byte is also sent under several transmit back-pressure lengths. During those waits a second byte is offered on the receive side, to show that the held value stays stable and the offered byte is neither taken nor mixed in. The button is pressed once while a byte is pending and then held for 40 cycles. This tells a true single-cycle edge pulse apart from a level-following reset, and shows that the pending byte is dropped.

// File: rtl/echo_pkg.sv
package echo_pkg;

    localparam int BYTE_W   = 8;
    localparam int CASE_BIT = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t UPPER_FIRST = 8'h41;
    localparam byte_t UPPER_LAST  = 8'h5A;
    localparam byte_t LOWER_FIRST = 8'h61;
    localparam byte_t LOWER_LAST  = 8'h7A;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_SEND = 2'd2
    } echo_st_e;

    // One-entry holding slot: occupancy flag plus byte
    typedef struct packed {
        logic  vld;
        byte_t dat;
    } slot_t;

    function automatic logic is_alpha(byte_t b);
        return ((b >= UPPER_FIRST) && (b <= UPPER_LAST)) ||
               ((b >= LOWER_FIRST) && (b <= LOWER_LAST));
    endfunction

    function automatic byte_t flip_case(byte_t b);
        byte_t r;
        r = b;
        if (is_alpha(b)) begin
            r[CASE_BIT] = ~b[CASE_BIT];
        end
        return r;
    endfunction

endpackage

// File: rtl/rst_edge_pulse.sv
module rst_edge_pulse #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);

    logic prev_q;
    logic pulse_q;
    logic edge_seen;

    generate
        if (RISING) begin : g_rise
            assign edge_seen = level_i & ~prev_q;
        end else begin : g_fall
            assign edge_seen = ~level_i & prev_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= level_i;
            pulse_q <= edge_seen;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/case_xform.sv
module case_xform
    import echo_pkg::*;
#(
    parameter bit FLIP_EN = 1'b1
) (
    input  byte_t din,
    output byte_t dout
);

    generate
        if (FLIP_EN) begin : g_flip
            assign dout = flip_case(din);
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/echo_fsm.sv
module echo_fsm
    import echo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  kill_i,
    input  byte_t rx_data_i,
    input  logic  rx_valid_i,
    output logic  rx_ready_o,
    output byte_t tx_data_o,
    output logic  tx_valid_o,
    input  logic  tx_ready_i
);

    echo_st_e state_q, state_d;
    slot_t    slot_q, slot_d;
    logic     take_rx;
    logic     give_tx;

    assign rx_ready_o = (state_q == ST_CAPT) & ~kill_i;
    assign tx_valid_o = slot_q.vld & ~kill_i;
    assign tx_data_o  = slot_q.dat;

    assign take_rx = rx_ready_o & rx_valid_i;
    assign give_tx = tx_valid_o & tx_ready_i;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_valid_i) begin
                    state_d = ST_CAPT;
                end
            end
            ST_CAPT: begin
                if (take_rx) begin
                    slot_d.vld = 1'b1;
                    slot_d.dat = rx_data_i;
                    state_d    = ST_SEND;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SEND: begin
                if (give_tx) begin
                    slot_d.vld = 1'b0;
                    state_d    = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                slot_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || kill_i) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

endmodule

// File: rtl/case_echo_ctrl.sv
module case_echo_ctrl
    import echo_pkg::*;
#(
    parameter bit FLIP_EN    = 1'b1,
    parameter bit RST_RISING = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_rst_level,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       rx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       soft_rst
);

    byte_t xf_data;
    byte_t held_data;
    logic  pulse;

    rst_edge_pulse #(
        .RISING (RST_RISING)
    ) u_rst_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (btn_rst_level),
        .pulse_o (pulse)
    );

    case_xform #(
        .FLIP_EN (FLIP_EN)
    ) u_xform (
        .din  (rx_data),
        .dout (xf_data)
    );

    echo_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kill_i     (pulse),
        .rx_data_i  (xf_data),
        .rx_valid_i (rx_valid),
        .rx_ready_o (rx_ready),
        .tx_data_o  (held_data),
        .tx_valid_o (tx_valid),
        .tx_ready_i (tx_ready)
    );

    assign tx_data  = held_data;
    assign soft_rst = pulse;

endmodule

// File: rtl/echo_chk.sv
module echo_chk (
    input logic       clk,
    input logic       rst,
    input logic       btn_rst_level,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       soft_rst
);

    AST_RDY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(rx_valid)); // R4

    AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready); // R4

    AST_CAPT_TO_SEND: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_valid) |=> (tx_valid || soft_rst)); // R5

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> ((tx_valid && $stable(tx_data)) || soft_rst)); // R5

    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid); // R6

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && tx_valid)); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst); // R8

    AST_PULSE_FROM_LEVEL: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_rst) |-> $past(btn_rst_level)); // R8

    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (!rx_ready && !tx_valid)); // R9

    AST_AFTER_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !tx_valid); // R9

endmodule

bind case_echo_ctrl echo_chk u_echo_chk (
    .clk           (clk),
    .rst           (rst),
    .btn_rst_level (btn_rst_level),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .tx_data       (tx_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .soft_rst      (soft_rst)
);

// File: tb/case_echo_ctrl_tb_top.sv
module case_echo_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       btn_rst_level;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       soft_rst;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic       mon_en = 1'b0;
    logic       prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;

    always #5 clk = ~clk;

    case_echo_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .btn_rst_level (btn_rst_level),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .soft_rst      (soft_rst)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference transform written from R1..R3
    function automatic logic [7:0] ref_out(input logic [7:0] b);
        if (b >= 8'h41 && b <= 8'h5A) return b + 8'h20;
        if (b >= 8'h61 && b <= 8'h7A) return b - 8'h20;
        return b;
    endfunction

    function automatic string cls(input logic [7:0] b);
        if (b >= 8'h41 && b <= 8'h5A) return "R1";
        if (b >= 8'h61 && b <= 8'h7A) return "R2";
        return "R3";
    endfunction

    // Per-clock monitor: one byte in flight and held data stable (R7, R5)
    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            chk(!(rx_ready && tx_valid), "R7 rdy_with_pending", {rx_ready, tx_valid}, 2'b00);
            if (prev_hold && !soft_rst)
                chk(tx_valid && tx_data == prev_data, "R5 hold_stable", tx_data, prev_data);
        end
        prev_hold = tx_valid && !tx_ready;
        prev_data = tx_data;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic echo_byte(input logic [7:0] b, input int hold);
        logic [7:0] exp;
        exp = ref_out(b);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        chk(rx_ready == 1'b1, "R4 ready_after_valid", rx_ready, 1);
        chk(tx_valid == 1'b0, "R4 no_tx_yet", tx_valid, 0);
        @(negedge clk);
        chk(rx_ready == 1'b0, "R4 ready_one_cycle", rx_ready, 0);
        chk(tx_valid == 1'b1, "R5 tx_valid_rise", tx_valid, 1);
        chk(tx_data == exp, cls(b), tx_data, exp);
        rx_valid = 1'b0;
        for (int i = 0; i < hold; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'h45;
            @(negedge clk);
            chk(tx_valid == 1'b1, "R5 valid_held", tx_valid, 1);
            chk(tx_data == exp, "R7 held_byte_kept", tx_data, exp);
            chk(rx_ready == 1'b0, "R7 no_accept_pending", rx_ready, 0);
        end
        rx_valid = 1'b0;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk(tx_valid == 1'b0, "R6 valid_drop", tx_valid, 0);
        chk(rx_ready == 1'b0, "R6 idle_after_send", rx_ready, 0);
    endtask

    initial begin
        rst           = 1'b1;
        btn_rst_level = 1'b0;
        rx_data       = 8'h00;
        rx_valid      = 1'b0;
        tx_ready      = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rx_ready && !tx_valid && !soft_rst, "R10 reset_state",
            {rx_ready, tx_valid, soft_rst}, 0);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;

        echo_byte(8'h41, 0);
        echo_byte(8'h61, 0);
        echo_byte(8'h40, 0);
        echo_byte(8'h5B, 0);
        echo_byte(8'h60, 0);
        echo_byte(8'h7B, 0);
        echo_byte(8'hC1, 0);
        echo_byte(8'hE1, 0);

        for (int v = 0; v < 256; v++) begin
            echo_byte(v[7:0], v % 4);
        end

        // Button press while a byte is pending (R8, R9)
        rx_data  = 8'h41;
        rx_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        chk(tx_valid == 1'b1, "R9 pending_before_press", tx_valid, 1);
        btn_rst_level = 1'b1;
        @(negedge clk);
        chk(soft_rst == 1'b1, "R8 pulse_high", soft_rst, 1);
        chk(tx_valid == 1'b0 && rx_ready == 1'b0, "R9 quiet_during_pulse",
            {tx_valid, rx_ready}, 0);
        @(negedge clk);
        chk(soft_rst == 1'b0, "R8 pulse_one_cycle", soft_rst, 0);
        chk(tx_valid == 1'b0, "R9 pending_dropped", tx_valid, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(soft_rst == 1'b0, "R8 no_repeat_while_held", soft_rst, 0);
        end
        btn_rst_level = 1'b0;
        @(negedge clk);
        chk(soft_rst == 1'b0, "R8 no_pulse_on_release", soft_rst, 0);
        echo_byte(8'h7A, 1);

        // System reset while a byte is pending (R10)
        rx_data  = 8'h5A;
        rx_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        mon_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !rx_ready && !soft_rst, "R10 reset_clears",
            {tx_valid, rx_ready, soft_rst}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R10 pending_gone", tx_valid, 0);
        mon_en = 1'b1;
        echo_byte(8'h3A, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule